// File: doc/BRIEF.md
# Atomic Swap Memory Controller

This block is a single-port, on-chip byte-addressed memory that serves plain reads and writes, invalidate or upgrade requests, and two atomic read-modify-write forms. An atomic request reads the location and writes it again in the same clock cycle, so no other request can come between the read and the write. An unconditional swap always stores the new operand. A compare-and-swap stores it only when the current contents equal the compare operand over the access width. Both forms return the old contents.

One request may be presented in any cycle. Each request returns exactly one response a fixed number of cycles later, set by the `LATENCY` parameter, and responses come back in issue order. The response carries the read data and a status code. Sub-word data occupies little-endian byte lanes chosen by the low address bits. Read data comes back right-aligned and zero-extended. When `ZERO_INIT` is set, reset clears the storage to zero.

Top module: `amo_mem_ctrl`

## Requirements
- R1: A read (opcode 0) of 1, 2, 4 or 8 bytes (size code 0..3 = 2^code bytes) returns the addressed bytes in little-endian order, right-aligned and zero-extended, with status 0. The response appears exactly `LATENCY` cycles after the request cycle.
- R2: A write (opcode 1) changes only the byte lanes it addresses. It returns data 0 and status 0.
- R3: A swap (opcode 3) of any of the four sizes returns the old contents and always stores the new operand.
- R4: A compare-and-swap (opcode 4) of 4 or 8 bytes returns the old contents with status 0 in every case. It stores the new operand only when the old value equals the low bytes of the compare operand.
- R5: A compare-and-swap of 1 or 2 bytes returns status 2 and data 0, and leaves memory unchanged.
- R6: An access whose address is not a multiple of its size returns status 1 and data 0, and leaves memory unchanged.
- R7: An access at an address of `MEM_BYTES` or above returns status 4 and data 0, and writes nothing anywhere.
- R8: An invalidate (opcode 2) returns status 0 and data 0 and leaves memory unchanged.
- R9: Opcodes 5 to 7 return status 3 and data 0 and leave memory unchanged. An opcode error takes priority over range, then alignment, then size errors.
- R10: After reset no response is pending and, with `ZERO_INIT` set, every location reads as zero.
- R11: Requests in consecutive cycles are each answered once, in order. Each request observes the memory effect of every earlier request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_op | input | 3 | Opcode: 0 read, 1 write, 2 invalidate, 3 swap, 4 compare-and-swap |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access size code, 2^code bytes |
| req_wdata | input | 64 | Write or swap operand, in the low bytes |
| req_cmp | input | 64 | Compare operand for compare-and-swap, in the low bytes |
| rsp_valid | output | 1 | A response is presented this cycle |
| rsp_data | output | 64 | Old or read data, right-aligned |
| rsp_status | output | 3 | 0 ok, 1 misaligned, 2 bad size, 3 bad opcode, 4 out of range |

## Verification
The hardest case to reach is a compare-and-swap that fails because another atomic operation changed the location in the cycle just before it. The failed compare must return the fresh value and must not store anything. The stimulus chains back-to-back swap, compare-and-swap and read requests on one word with no idle cycle between them. Every response is scored against a byte-level reference memory, so any stale read or lost write shows up in the next response for that word. Error cases are followed by reads of the same and wrapped addresses, which show at the ports that nothing was written.

// File: rtl/amo_pkg.sv
package amo_pkg;
    localparam int WORD_BYTES = 8;
    localparam int WORD_BITS  = 64;

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_INVAL = 3'd2,
        OP_SWAP  = 3'd3,
        OP_CAS   = 3'd4
    } amo_op_e;

    typedef enum logic [2:0] {
        ST_OK     = 3'd0,
        ST_ALIGN  = 3'd1,
        ST_SIZE   = 3'd2,
        ST_OPCODE = 3'd3,
        ST_RANGE  = 3'd4
    } amo_stat_e;

    typedef struct packed {
        logic                 vld;
        logic [WORD_BITS-1:0] data;
        amo_stat_e            stat;
    } amo_rsp_t;
endpackage

// File: rtl/amo_decode.sv
module amo_decode
    import amo_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int MEM_BYTES = 256
) (
    input  logic [2:0]            op,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [1:0]            size,
    output amo_stat_e             stat,
    output logic [WORD_BYTES-1:0] lane_mask
);
    logic        known;
    logic        misal;
    logic        in_range;
    logic [31:0] addr_ext;
    logic [7:0]  base_mask;

    assign addr_ext = 32'(addr);
    assign in_range = addr_ext < 32'(MEM_BYTES);

    always_comb begin
        unique case (op)
            OP_READ, OP_WRITE, OP_INVAL, OP_SWAP, OP_CAS: known = 1'b1;
            default:                                      known = 1'b0;
        endcase
    end

    always_comb begin
        unique case (size)
            2'd0: begin misal = 1'b0;        base_mask = 8'h01; end
            2'd1: begin misal = addr[0];     base_mask = 8'h03; end
            2'd2: begin misal = |addr[1:0];  base_mask = 8'h0F; end
            default: begin misal = |addr[2:0]; base_mask = 8'hFF; end
        endcase
    end

    assign lane_mask = base_mask << addr[2:0];

    always_comb begin
        if (!known)                          stat = ST_OPCODE;
        else if (op == OP_INVAL)             stat = ST_OK;
        else if (!in_range)                  stat = ST_RANGE;
        else if (misal)                      stat = ST_ALIGN;
        else if (op == OP_CAS && !size[1])   stat = ST_SIZE;
        else                                 stat = ST_OK;
    end
endmodule

// File: rtl/amo_exec.sv
module amo_exec
    import amo_pkg::*;
#(
    parameter int MEM_BYTES = 256,
    parameter bit ZERO_INIT = 1'b1,
    localparam int WORDS  = MEM_BYTES / WORD_BYTES,
    localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  valid,
    input  logic [2:0]            op,
    input  amo_stat_e             stat,
    input  logic [WIDX_W-1:0]     word_idx,
    input  logic [2:0]            lane_off,
    input  logic [WORD_BYTES-1:0] lane_mask,
    input  logic [1:0]            size,
    input  logic [WORD_BITS-1:0]  wdata,
    input  logic [WORD_BITS-1:0]  cmp,
    output logic [WORD_BITS-1:0]  rd_data,
    output logic                  we
);
    logic [WORD_BITS-1:0] mem_q [WORDS];
    logic [WORD_BITS-1:0] old_word, shifted, old_val, size_mask;
    logic [WORD_BITS-1:0] ins, bmask, new_word;
    logic                 cmp_eq;
    logic                 ok;

    assign ok       = valid && (stat == ST_OK);
    assign old_word = mem_q[word_idx];
    assign shifted  = old_word >> {lane_off, 3'b000};

    always_comb begin
        unique case (size)
            2'd0:    size_mask = 64'h0000_0000_0000_00FF;
            2'd1:    size_mask = 64'h0000_0000_0000_FFFF;
            2'd2:    size_mask = 64'h0000_0000_FFFF_FFFF;
            default: size_mask = '1;
        endcase
    end

    assign old_val = shifted & size_mask;
    assign cmp_eq  = (old_val == (cmp & size_mask));
    assign ins     = (wdata & size_mask) << {lane_off, 3'b000};

    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
        assign bmask[8*b +: 8] = {8{lane_mask[b]}};
    end

    assign new_word = (old_word & ~bmask) | (ins & bmask);

    always_comb begin
        we      = 1'b0;
        rd_data = '0;
        if (ok) begin
            unique case (op)
                OP_READ:  rd_data = old_val;
                OP_WRITE: we = 1'b1;
                OP_SWAP:  begin we = 1'b1;   rd_data = old_val; end
                OP_CAS:   begin we = cmp_eq; rd_data = old_val; end
                default:  ;
            endcase
        end
    end

    if (ZERO_INIT) begin : g_zero
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int w = 0; w < WORDS; w++) mem_q[w] <= '0;
            end else if (we) begin
                mem_q[word_idx] <= new_word;
            end
        end
    end else begin : g_keep
        always_ff @(posedge clk) begin
            if (we) mem_q[word_idx] <= new_word;
        end
    end

    AST_SIZE_NO_WRITE:   assert property (@(posedge clk) disable iff (!rst_n) (valid && stat == ST_SIZE) |-> !we);   // R5
    AST_ALIGN_NO_WRITE:  assert property (@(posedge clk) disable iff (!rst_n) (valid && stat == ST_ALIGN) |-> !we);  // R6
    AST_RANGE_NO_WRITE:  assert property (@(posedge clk) disable iff (!rst_n) (valid && stat == ST_RANGE) |-> !we);  // R7
    AST_INVAL_NO_WRITE:  assert property (@(posedge clk) disable iff (!rst_n) (valid && op == OP_INVAL) |-> !we);    // R8
    AST_OPCODE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (valid && stat == ST_OPCODE) |-> !we); // R9
    AST_CAS_MISS_KEEP:   assert property (@(posedge clk) disable iff (!rst_n) (ok && op == OP_CAS && !cmp_eq) |=> $stable(mem_q[$past(word_idx)])); // R4
endmodule

// File: rtl/amo_delay.sv
module amo_delay
    import amo_pkg::*;
#(
    parameter int LATENCY = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  amo_rsp_t d_in,
    output amo_rsp_t d_out
);
    amo_rsp_t stage_q [LATENCY];

    for (genvar i = 0; i < LATENCY; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[i] <= '0;
                else        stage_q[i] <= d_in;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[i] <= '0;
                else        stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign d_out = stage_q[LATENCY-1];
endmodule

// File: rtl/amo_mem_ctrl.sv
module amo_mem_ctrl
    import amo_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int MEM_BYTES = 256,
    parameter int LATENCY   = 3,
    parameter bit ZERO_INIT = 1'b1,
    localparam int WORDS    = MEM_BYTES / WORD_BYTES,
    localparam int WIDX_W   = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int CNT_W    = $clog2(LATENCY + 2) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [2:0]           req_op,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [1:0]           req_size,
    input  logic [WORD_BITS-1:0] req_wdata,
    input  logic [WORD_BITS-1:0] req_cmp,
    output logic                 rsp_valid,
    output logic [WORD_BITS-1:0] rsp_data,
    output logic [2:0]           rsp_status
);
    amo_stat_e             dec_stat;
    logic [WORD_BYTES-1:0] lane_mask;
    logic [WORD_BITS-1:0]  rd_data;
    logic                  mem_we;
    amo_rsp_t              rsp_in, rsp_out;

    amo_decode #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u_dec (
        .op        (req_op),
        .addr      (req_addr),
        .size      (req_size),
        .stat      (dec_stat),
        .lane_mask (lane_mask)
    );

    amo_exec #(.MEM_BYTES(MEM_BYTES), .ZERO_INIT(ZERO_INIT)) u_exec (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (req_valid),
        .op        (req_op),
        .stat      (dec_stat),
        .word_idx  (req_addr[3 +: WIDX_W]),
        .lane_off  (req_addr[2:0]),
        .lane_mask (lane_mask),
        .size      (req_size),
        .wdata     (req_wdata),
        .cmp       (req_cmp),
        .rd_data   (rd_data),
        .we        (mem_we)
    );

    always_comb begin
        rsp_in.vld  = req_valid;
        rsp_in.data = rd_data;
        rsp_in.stat = req_valid ? dec_stat : ST_OK;
    end

    amo_delay #(.LATENCY(LATENCY)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (rsp_in),
        .d_out (rsp_out)
    );

    assign rsp_valid  = rsp_out.vld;
    assign rsp_data   = rsp_out.data;
    assign rsp_status = rsp_out.stat;

    logic [CNT_W-1:0] inflight_q;
    always_ff @(posedge clk) begin
        if (!rst_n) inflight_q <= '0;
        else        inflight_q <= inflight_q + CNT_W'(req_valid) - CNT_W'(rsp_valid);
    end

    AST_NO_ORPHAN_RSP: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> (inflight_q != '0)); // R1
    AST_INFLIGHT_CAP:  assert property (@(posedge clk) disable iff (!rst_n) inflight_q <= CNT_W'(LATENCY));  // R11
    AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_status != 3'd0) |-> (rsp_data == '0)); // R6
endmodule

// File: tb/sim_amo_mem_ctrl.sv
module sim_amo_mem_ctrl;
    localparam int ADDR_W = 9;
    localparam int MEMB   = 256;
    localparam int LAT    = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [2:0]  req_op;
    logic [8:0]  req_addr;
    logic [1:0]  req_size;
    logic [63:0] req_wdata, req_cmp;
    logic        rsp_valid;
    logic [63:0] rsp_data;
    logic [2:0]  rsp_status;

    always #10 clk = ~clk;

    amo_mem_ctrl #(.ADDR_W(ADDR_W), .MEM_BYTES(MEMB), .LATENCY(LAT), .ZERO_INIT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .req_cmp(req_cmp), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_status(rsp_status)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;
    bit live   = 1'b0;

    logic [7:0]  ref_mem [MEMB];
    logic [63:0] q_d [$];
    logic [2:0]  q_s [$];
    int          q_due [$];
    string       q_tag [$];

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model(input logic [2:0] op, input int a, input logic [1:0] sz,
                         input logic [63:0] wd, input logic [63:0] cm,
                         output logic [63:0] d, output logic [2:0] s);
        int nb = 1 << sz;
        logic [63:0] old = '0;
        logic [63:0] m = (sz == 2'd3) ? '1 : ((64'd1 << (8 * nb)) - 64'd1);
        d = '0;
        if (op > 3'd4)                         s = 3'd3;
        else if (op == 3'd2)                   s = 3'd0;
        else if (a >= MEMB)                    s = 3'd4;
        else if ((a % nb) != 0)                s = 3'd1;
        else if (op == 3'd4 && sz < 2'd2)      s = 3'd2;
        else begin
            s = 3'd0;
            for (int i = 0; i < nb; i++) old[8*i +: 8] = ref_mem[a+i];
            if (op != 3'd1) d = old;
            if (op == 3'd1 || op == 3'd3 || (op == 3'd4 && old == (cm & m)))
                for (int i = 0; i < nb; i++) ref_mem[a+i] = wd[8*i +: 8];
        end
    endtask

    task automatic issue(input logic [2:0] op, input int a, input logic [1:0] sz,
                         input logic [63:0] wd, input logic [63:0] cm, input string tag);
        logic [63:0] d;
        logic [2:0]  s;
        @(negedge clk);
        model(op, a, sz, wd, cm, d, s);
        q_d.push_back(d);
        q_s.push_back(s);
        q_due.push_back(cyc + LAT);
        q_tag.push_back(tag);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = 9'(a);
        req_size  = sz;
        req_wdata = wd;
        req_cmp   = cm;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // scoreboard monitor
    initial forever begin
        @(negedge clk);
        if (live && rsp_valid) begin
            if (q_d.size() == 0) begin
                chk("R11", "unexpected response", 64'd1, 64'd0);
            end else begin
                string t = q_tag.pop_front();
                chk(t, "data", rsp_data, q_d.pop_front());
                chk(t, "status", 64'(rsp_status), 64'(q_s.pop_front()));
                chk("R1", "latency cycle", 64'(cyc), 64'(q_due.pop_front()));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R11 actual=hung expected=done");
            report();
        end
    end

    initial begin
        for (int i = 0; i < MEMB; i++) ref_mem[i] = 8'h00;
        rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0;
        req_size = '0; req_wdata = '0; req_cmp = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        live = 1'b1;

        issue(3'd0, 'h10, 2'd3, 0, 0, "R10");
        issue(3'd0, 'hF8, 2'd3, 0, 0, "R10");
        idle(LAT + 1);

        issue(3'd1, 'h20, 2'd3, 64'h1122_3344_5566_7788, 0, "R2");
        issue(3'd0, 'h20, 2'd3, 0, 0, "R1");
        issue(3'd0, 'h21, 2'd0, 0, 0, "R1");
        issue(3'd0, 'h26, 2'd1, 0, 0, "R1");
        issue(3'd0, 'h24, 2'd2, 0, 0, "R1");
        issue(3'd1, 'h23, 2'd0, 64'hFFFF_FFFF_FFFF_FFAB, 0, "R2");
        issue(3'd0, 'h20, 2'd3, 0, 0, "R2");
        idle(2);

        issue(3'd3, 'h24, 2'd2, 64'h0BAD_F00D_DEAD_BEEF, 0, "R3");
        issue(3'd3, 'h27, 2'd0, 64'h5A, 0, "R3");
        issue(3'd3, 'h22, 2'd1, 64'hC0DE, 0, "R3");
        issue(3'd3, 'h30, 2'd3, 64'hA5A5_0000_1234_5678, 0, "R3");
        issue(3'd0, 'h20, 2'd3, 0, 0, "R3");
        issue(3'd0, 'h30, 2'd3, 0, 0, "R3");
        idle(2);

        issue(3'd4, 'h40, 2'd3, 64'h5555, 64'h0, "R4");
        issue(3'd4, 'h40, 2'd3, 64'h7777, 64'h0, "R4");
        issue(3'd0, 'h40, 2'd3, 0, 0, "R4");
        issue(3'd4, 'h44, 2'd2, 64'h89AB_CDEF, 64'hFFFF_FFFF_0000_0000, "R4");
        issue(3'd4, 'h44, 2'd2, 64'h1, 64'h89AB_CDEF, "R4");
        issue(3'd0, 'h40, 2'd3, 0, 0, "R4");
        idle(2);

        issue(3'd4, 'h20, 2'd0, 64'hEE, 64'h88, "R5");
        issue(3'd4, 'h20, 2'd1, 64'hEEEE, 64'h7788, "R5");
        issue(3'd0, 'h20, 2'd3, 0, 0, "R5");
        issue(3'd1, 'h22, 2'd2, 64'hFFFF_FFFF, 0, "R6");
        issue(3'd3, 'h41, 2'd1, 64'hFFFF, 0, "R6");
        issue(3'd4, 'h44, 2'd3, 64'h1, 64'h5555, "R6");
        issue(3'd0, 'h20, 2'd3, 0, 0, "R6");
        issue(3'd0, 'h40, 2'd3, 0, 0, "R6");
        idle(2);

        issue(3'd1, 'h100, 2'd3, 64'hDEAD_DEAD_DEAD_DEAD, 0, "R7");
        issue(3'd3, 'h1F8, 2'd3, 64'hBEEF, 0, "R7");
        issue(3'd0, 'h120, 2'd3, 0, 0, "R7");
        issue(3'd0, 'h00, 2'd3, 0, 0, "R7");
        issue(3'd0, 'hF8, 2'd3, 0, 0, "R7");
        issue(3'd2, 'h20, 2'd3, 64'hFFFF, 64'hFFFF, "R8");
        issue(3'd2, 'h1FF, 2'd1, 0, 0, "R8");
        issue(3'd0, 'h20, 2'd3, 0, 0, "R8");
        issue(3'd5, 'h20, 2'd3, 64'h1, 0, "R9");
        issue(3'd7, 'h101, 2'd1, 64'h1, 0, "R9");
        issue(3'd6, 'h40, 2'd3, 64'h1, 64'h5555, "R9");
        issue(3'd0, 'h20, 2'd3, 0, 0, "R9");
        issue(3'd0, 'h40, 2'd3, 0, 0, "R9");
        idle(2);

        issue(3'd3, 'h60, 2'd3, 64'h1111, 0, "R11");
        issue(3'd4, 'h60, 2'd3, 64'h2222, 64'h0, "R11");
        issue(3'd4, 'h60, 2'd3, 64'h3333, 64'h1111, "R11");
        issue(3'd0, 'h60, 2'd3, 0, 0, "R11");
        issue(3'd3, 'h64, 2'd2, 64'h4444, 0, "R11");
        issue(3'd4, 'h60, 2'd3, 64'h9, 64'h3333, "R11");
        issue(3'd0, 'h60, 2'd3, 0, 0, "R11");
        idle(LAT + 3);

        chk("R11", "responses outstanding", 64'(q_d.size()), 64'd0);
        done = 1'b1;
        report();
    end
endmodule